// File: doc/BRIEF.md
# Random Source Status and Alarm Controller

This block is the register-side front end of a hardware random number generator. Once software sets the generator enable, a refill state machine takes four 32-bit words, one per cycle, from an external noise word source. It then waits a programmable settle time and raises a ready flag in the interrupt status register. The four words stay frozen and readable until software clears the ready flag with a write-one-to-clear. That clear starts the next refill. While capturing, the block compares each word with the one captured before it and flags a stuck output when the two are equal.

Health-test failure pulses from outside set sticky status bits. A level interrupt is the OR of the status bits 7 to 1, each gated by its own enable bit in the control register. A separate alarm tracker counts oscillator alarm pulses against a threshold. The first threshold crossing only arms a warning. The second stops the unmasked oscillators that were alarming, records them in a stop register, and sets the shutdown status bit. Writing all ones to the oscillator enable register restarts the bank and re-arms the tracker.

Refill state machine: GEN_OFF goes to GEN_FILL when the generator is enabled and ready is clear. GEN_FILL goes to GEN_SETTLE after the fourth word. GEN_SETTLE goes to GEN_HOLD when the settle count is reached, setting ready. GEN_HOLD goes back to GEN_FILL, or to GEN_OFF if the generator is disabled, once ready is cleared. Every state falls to GEN_OFF when the enable drops. Alarm tracker: ALM_ARMED goes to ALM_WARNED on the first alarm event. ALM_WARNED goes to ALM_TRIPPED on the second, which stops oscillators. ALM_TRIPPED keeps stopping oscillators on further events. Any state returns to ALM_ARMED on an all-ones write to the enable register.

Top module: `rng_alarm_ctrl`

## Requirements
- R1: After reset, status, control and oscillator enables read zero and irq is low. The revision register at 0x7C returns the major revision in bits 27:24, the minor revision in bits 23:20 and the patch level in bits 19:16.
- R2: With control bit 10 set, the block captures four consecutive noise words while `noise_take` is high, in order. It then sets status bit 0 (ready). The words read back at 0x00, 0x04, 0x08 and 0x0C.
- R3: While status bit 0 is set, `noise_take` stays low and the words do not change. Writing 1 to status bit 0 at 0x10 starts the next refill.
- R4: A write to the status register clears exactly those bits written as 1. Bits written as 0 are unchanged.
- R5: When a status bit is set by its source in the same cycle that a write clears it, the bit ends set.
- R6: irq is high exactly when some status bit 7..1 is set with the same control bit set. The ready bit never raises irq.
- R7: Capturing a word equal to the previously captured word sets status bit 2.
- R8: A one-cycle pulse on `hc_fail[i]` sets status bit 3+i (noise, run, long-run, poker, monobit for i=0..4), and the bit stays set until cleared.
- R9: The first alarm event stops no oscillator. The second clears `osc_en` for the unmasked alarming oscillators, records them in the stop register at 0x2C, and sets status bit 1.
- R10: An alarm event occurs when the count of cycles with an unmasked alarm reaches the threshold in bits 7:0 of 0x1C. Alarms on oscillators masked in 0x28 are not counted.
- R11: Writing 0xFFFFFFFF to 0x20 enables all oscillators, clears the stop register and re-arms the tracker, so the next event stops nothing.
- R12: Config at 0x18 keeps bits 31:16 and 7:0. Ready rises N cycles after the last capture edge, where N is bits 7:0 of the config register, with 0 treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| noise_word | input | 32 | Word from the noise source |
| noise_take | output | 1 | Word on `noise_word` is captured at this edge |
| hc_fail | input | 5 | Health-test failure pulses |
| osc_alarm | input | NUM_OSC | Per-oscillator alarm pulses |
| osc_en | output | NUM_OSC | Oscillator enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench times the gap between the last capture and ready, because an off-by-one settle counter shows up as a ready flag one cycle early or late. It holds ready set and counts captures, since a design that refills without waiting for the clear would overwrite words software has not yet read. It drives a health pulse into the same cycle as its clear, which a design with clear priority would lose. It counts masked and unmasked alarm pulses up to the threshold on each side of the first event. A tracker that trips on the first event, or counts masked alarms, stops oscillators too early. One that does not re-arm after restart stops them on the next single event.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
    localparam int NUM_WORDS = 4;
    localparam int DATA_W    = 32;

    localparam logic [7:0] A_WORD0  = 8'h00;
    localparam logic [7:0] A_STATUS = 8'h10;
    localparam logic [7:0] A_CTRL   = 8'h14;
    localparam logic [7:0] A_CFG    = 8'h18;
    localparam logic [7:0] A_THRESH = 8'h1C;
    localparam logic [7:0] A_OSC_EN = 8'h20;
    localparam logic [7:0] A_DETUNE = 8'h24;
    localparam logic [7:0] A_MASK   = 8'h28;
    localparam logic [7:0] A_STOP   = 8'h2C;
    localparam logic [7:0] A_OPTS   = 8'h78;
    localparam logic [7:0] A_REV    = 8'h7C;

    localparam int CTRL_GEN = 10;
    localparam logic [31:0] CTRL_WMASK = 32'h0000_04FE;
    localparam logic [31:0] CFG_WMASK  = 32'hFFFF_00FF;

    typedef enum logic [1:0] {GEN_OFF, GEN_FILL, GEN_SETTLE, GEN_HOLD} gen_state_e;
    typedef enum logic [1:0] {ALM_ARMED, ALM_WARNED, ALM_TRIPPED} alm_state_e;
endpackage

// File: rtl/rngc_fill.sv
module rngc_fill
    import rngc_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 gen_en,
    input  logic [7:0]                           settle_cyc,
    input  logic                                 ready_q,
    input  logic [DATA_W-1:0]                    noise_word,
    output logic                                 noise_take,
    output logic                                 ready_set,
    output logic                                 stuck_set,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]     words
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    gen_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       wcnt_q;
    logic [DATA_W-1:0] prev_q;
    logic             prev_vld_q;
    logic [8:0]       lim;
    logic             settle_done;

    assign lim         = (settle_cyc == 8'd0) ? 9'd1 : {1'b0, settle_cyc};
    assign settle_done = ({1'b0, wcnt_q} + 9'd1) >= lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_OFF:    if (gen_en && !ready_q) state_d = GEN_FILL;
            GEN_FILL:   if (!gen_en) state_d = GEN_OFF;
                        else if (idx_q == IDX_W'(NUM_WORDS - 1)) state_d = GEN_SETTLE;
            GEN_SETTLE: if (!gen_en) state_d = GEN_OFF;
                        else if (settle_done) state_d = GEN_HOLD;
            GEN_HOLD:   if (!gen_en) state_d = GEN_OFF;
                        else if (!ready_q) state_d = GEN_FILL;
            default:    state_d = GEN_OFF;
        endcase
    end

    always_comb begin
        noise_take = (state_q == GEN_FILL) && gen_en;
        ready_set  = (state_q == GEN_SETTLE) && gen_en && settle_done;
        stuck_set  = noise_take && prev_vld_q && (noise_word == prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            wcnt_q     <= '0;
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else begin
            if (noise_take) begin
                idx_q      <= (idx_q == IDX_W'(NUM_WORDS - 1)) ? '0 : idx_q + 1'b1;
                prev_q     <= noise_word;
                prev_vld_q <= 1'b1;
            end else if (state_q != GEN_FILL) begin
                idx_q <= '0;
            end
            wcnt_q <= (state_q == GEN_SETTLE) ? wcnt_q + 8'd1 : 8'd0;
        end
    end

    for (genvar gw = 0; gw < NUM_WORDS; gw++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[gw] <= '0;
            else if (noise_take && idx_q == IDX_W'(gw))
                words[gw] <= noise_word;
        end
    end
endmodule

// File: rtl/rngc_alarm.sv
module rngc_alarm
    import rngc_pkg::*;
#(
    parameter int NUM_OSC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_alarm,
    input  logic [7:0]         thresh,
    input  logic               mask_we,
    input  logic               en_we,
    input  logic [31:0]        wdata,
    output logic [NUM_OSC-1:0] osc_en,
    output logic [NUM_OSC-1:0] stop_q,
    output logic [NUM_OSC-1:0] mask_q,
    output logic               shut_set
);
    alm_state_e state_q, state_d;
    logic [7:0]         cnt_q;
    logic [NUM_OSC-1:0] live;
    logic               hit, evt, restart;
    logic [8:0]         thr;

    assign live    = osc_alarm & ~mask_q;
    assign hit     = |live;
    assign thr     = (thresh == 8'd0) ? 9'd1 : {1'b0, thresh};
    assign evt     = hit && (({1'b0, cnt_q} + 9'd1) >= thr);
    assign restart = en_we && (&wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_ARMED:   if (evt) state_d = ALM_WARNED;
            ALM_WARNED:  if (evt) state_d = ALM_TRIPPED;
            ALM_TRIPPED: state_d = ALM_TRIPPED;
            default:     state_d = ALM_ARMED;
        endcase
        if (restart) state_d = ALM_ARMED;
    end

    always_comb begin
        shut_set = evt && !en_we && (state_q != ALM_ARMED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            osc_en <= '0;
            stop_q <= '0;
            mask_q <= '0;
        end else begin
            if (mask_we) mask_q <= wdata[NUM_OSC-1:0];
            if (restart)  cnt_q <= '0;
            else if (hit) cnt_q <= evt ? 8'd0 : cnt_q + 8'd1;
            if (en_we) begin
                osc_en <= wdata[NUM_OSC-1:0];
                if (restart) stop_q <= '0;
            end else if (shut_set) begin
                stop_q <= stop_q | (live & osc_en);
                osc_en <= osc_en & ~live;
            end
        end
    end
endmodule

// File: rtl/rng_alarm_ctrl.sv
module rng_alarm_ctrl
    import rngc_pkg::*;
#(
    parameter int NUM_OSC   = 8,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1,
    parameter int REV_PATCH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [31:0]        noise_word,
    output logic               noise_take,
    input  logic [4:0]         hc_fail,
    input  logic [NUM_OSC-1:0] osc_alarm,
    output logic [NUM_OSC-1:0] osc_en,
    output logic               irq
);
    localparam logic [31:0] REV_VAL = {4'h0, 4'(REV_MAJOR), 4'(REV_MINOR), 4'(REV_PATCH), 16'h0};
    localparam logic [31:0] OPT_VAL = {16'h0, 8'(NUM_OSC), 8'(NUM_WORDS)};

    logic [7:0]  status_q;
    logic [31:0] ctrl_q, cfg_q, detune_q;
    logic [7:0]  thresh_q;
    logic        ready_set, stuck_set, shut_set;
    logic [7:0]  set_vec, clr_vec;
    logic [NUM_OSC-1:0] stop_q, mask_q;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    rngc_fill u_fill (
        .clk(clk), .rst_n(rst_n), .gen_en(ctrl_q[CTRL_GEN]),
        .settle_cyc(cfg_q[7:0]), .ready_q(status_q[0]),
        .noise_word(noise_word), .noise_take(noise_take),
        .ready_set(ready_set), .stuck_set(stuck_set), .words(words)
    );

    rngc_alarm #(.NUM_OSC(NUM_OSC)) u_alarm (
        .clk(clk), .rst_n(rst_n), .osc_alarm(osc_alarm), .thresh(thresh_q),
        .mask_we(wr_en && addr == A_MASK), .en_we(wr_en && addr == A_OSC_EN),
        .wdata(wdata), .osc_en(osc_en), .stop_q(stop_q), .mask_q(mask_q),
        .shut_set(shut_set)
    );

    assign set_vec = {hc_fail, stuck_set, shut_set, ready_set};
    assign clr_vec = (wr_en && addr == A_STATUS) ? wdata[7:0] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            ctrl_q   <= '0;
            cfg_q    <= '0;
            thresh_q <= '0;
            detune_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (wr_en) begin
                unique case (addr)
                    A_CTRL:   ctrl_q   <= wdata & CTRL_WMASK;
                    A_CFG:    cfg_q    <= wdata & CFG_WMASK;
                    A_THRESH: thresh_q <= wdata[7:0];
                    A_DETUNE: detune_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign irq = |(status_q[7:1] & ctrl_q[7:1]);

    always_comb begin
        rdata = '0;
        if (addr[7:4] == 4'h0 && addr[1:0] == 2'b00) begin
            rdata = words[addr[3:2]];
        end else begin
            case (addr)
                A_STATUS: rdata = {24'h0, status_q};
                A_CTRL:   rdata = ctrl_q;
                A_CFG:    rdata = cfg_q;
                A_THRESH: rdata = {24'h0, thresh_q};
                A_OSC_EN: rdata = 32'(osc_en);
                A_DETUNE: rdata = detune_q;
                A_MASK:   rdata = 32'(mask_q);
                A_STOP:   rdata = 32'(stop_q);
                A_OPTS:   rdata = OPT_VAL;
                A_REV:    rdata = REV_VAL;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rngc_chk.sv
module rngc_chk #(
    parameter int NUM_OSC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [7:0]         addr,
    input logic [31:0]        wdata,
    input logic               noise_take,
    input logic [4:0]         hc_fail,
    input logic [NUM_OSC-1:0] osc_en,
    input logic               irq,
    input logic [7:0]         status_q,
    input logic [31:0]        ctrl_q
);
    logic [3:0] run_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_cnt <= '0;
        else        run_cnt <= noise_take ? run_cnt + 4'd1 : 4'd0;
    end

    // R3
    take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[0] |-> !noise_take);

    // R2
    four_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(noise_take) |-> (run_cnt == 4'd4 || !ctrl_q[10]));

    // R6
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[7:1] == 7'd0) |-> !irq);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h10 && wdata[3] && hc_fail[0]) |=> status_q[3]);

    // R9
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|($past(osc_en) & ~osc_en)) && !$past(wr_en && addr == 8'h20)) |-> status_q[1]);
endmodule

bind rng_alarm_ctrl rngc_chk #(.NUM_OSC(NUM_OSC)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .noise_take(noise_take), .hc_fail(hc_fail), .osc_en(osc_en), .irq(irq),
    .status_q(status_q), .ctrl_q(ctrl_q)
);

// File: tb/rng_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module rng_alarm_ctrl_tb_top;
    localparam int NOSC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] noise_word = 32'h1234_5678;
    logic noise_take;
    logic [4:0] hc_fail = '0;
    logic [NOSC-1:0] osc_alarm = '0;
    logic [NOSC-1:0] osc_en;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    int take_cnt = 0;
    bit hold_word = 0;
    bit adv_pend = 0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    rng_alarm_ctrl #(.NUM_OSC(NOSC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .noise_word(noise_word), .noise_take(noise_take),
        .hc_fail(hc_fail), .osc_alarm(osc_alarm), .osc_en(osc_en), .irq(irq)
    );

    // noise stub and driver side of the scoreboard
    always @(negedge clk) begin
        if (adv_pend && !hold_word) noise_word = noise_word + 32'h9E37_79B9;
        adv_pend = 0;
        if (noise_take) begin
            exp_q.push_back(noise_word);
            adv_pend = 1;
            take_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            bus_rd(8'h10, s);
            if (s[0]) return;
        end
        check("R2 ready timeout", 32'd0, 32'd1);
    endtask

    // monitor side: pop expected words and compare with readback
    task automatic compare_set(input string req);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            bus_rd(8'(i * 4), d);
            if (exp_q.size() == 0) check({req, " empty queue"}, d, 32'hxxxx_xxxx);
            else check(req, d, exp_q.pop_front());
        end
    endtask

    task automatic alarm_pulse(input logic [NOSC-1:0] v);
        @(negedge clk); osc_alarm = v;
        @(negedge clk); osc_alarm = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_rd(8'h10, d); check("R1 status", d, 32'h0);
        bus_rd(8'h14, d); check("R1 ctrl", d, 32'h0);
        check("R1 osc_en", 32'(osc_en), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        bus_rd(8'h7C, d); check("R1 revision fields", d, 32'h0213_0000);

        // R12 config storage and settle delay
        bus_wr(8'h18, 32'hABCD_1205);
        bus_rd(8'h18, d); check("R12 config readback", d, 32'hABCD_0005);

        // R2 first fill, timing of ready against last capture
        bus_wr(8'h14, 32'h0000_0400);
        k = -1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); addr = 8'h10; #1;
            if (noise_take) k = 0;
            else if (k >= 0) k++;
            if (rdata[0]) break;
        end
        check("R12 settle cycles", 32'(k), 32'd6);
        compare_set("R2 words set1");

        // R3 hold while ready
        k = take_cnt;
        repeat (20) @(negedge clk);
        check("R3 no capture while ready", 32'(take_cnt), 32'(k));
        bus_wr(8'h10, 32'h1);
        wait_ready();
        check("R3 refill after clear", 32'(take_cnt), 32'(k + 4));
        compare_set("R2 words set2");

        // R7 stuck detection
        hold_word = 1;
        bus_wr(8'h10, 32'h1);
        wait_ready();
        hold_word = 0;
        bus_rd(8'h10, d); check("R7 stuck bit", 32'(d[2]), 32'h1);
        compare_set("R7 words held");
        // R4 clear only written ones
        bus_wr(8'h10, 32'h4);
        bus_rd(8'h10, d); check("R4 w1c selective", d, 32'h1);

        // R8 health fail sticky, R6 gating
        @(negedge clk); hc_fail = 5'b10000;
        @(negedge clk); hc_fail = '0;
        repeat (3) @(negedge clk);
        bus_rd(8'h10, d); check("R8 monobit bit7", d, 32'h81);
        check("R6 irq gated off", 32'(irq), 32'h0);
        bus_wr(8'h14, 32'h0000_04FF);
        #1 check("R6 irq enabled", 32'(irq), 32'h1);
        bus_wr(8'h10, 32'h80);
        bus_rd(8'h10, d); check("R4 clear bit7", d, 32'h1);
        check("R6 ready alone no irq", 32'(irq), 32'h0);

        // R5 set beats clear
        @(negedge clk); hc_fail = 5'b00001; wr_en = 1; addr = 8'h10; wdata = 32'h8;
        @(negedge clk); hc_fail = '0; wr_en = 0;
        bus_rd(8'h10, d); check("R5 set over clear", 32'(d[3]), 32'h1);
        bus_wr(8'h10, 32'h8);
        bus_rd(8'h10, d); check("R4 clear bit3", 32'(d[3]), 32'h0);

        // R11 restart, R10 threshold and mask, R9 second event
        bus_wr(8'h20, 32'hFFFF_FFFF);
        check("R11 all enabled", 32'(osc_en), 32'hFF);
        bus_wr(8'h1C, 32'h3);
        bus_wr(8'h28, 32'h1);
        repeat (5) alarm_pulse(8'h01);
        repeat (3) alarm_pulse(8'h02);
        check("R9 first event no stop", 32'(osc_en), 32'hFF);
        bus_rd(8'h10, d); check("R9 no shutdown flag", 32'(d[1]), 32'h0);
        repeat (4) alarm_pulse(8'h01);
        repeat (2) alarm_pulse(8'h04);
        check("R10 masked not counted", 32'(osc_en), 32'hFF);
        alarm_pulse(8'h0C);
        check("R9 second event stops", 32'(osc_en), 32'hF3);
        bus_rd(8'h2C, d); check("R9 stop register", d, 32'h0C);
        bus_rd(8'h10, d); check("R9 shutdown flag", 32'(d[1]), 32'h1);
        check("R6 irq shutdown", 32'(irq), 32'h1);

        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_wr(8'h10, 32'h2);
        check("R11 restarted", 32'(osc_en), 32'hFF);
        bus_rd(8'h2C, d); check("R11 stop cleared", d, 32'h0);
        repeat (3) alarm_pulse(8'h02);
        check("R11 rearmed first event", 32'(osc_en), 32'hFF);
        bus_rd(8'h10, d); check("R11 no flag after rearm", 32'(d[1]), 32'h0);

        summary();
    end
endmodule